// File: doc/BRIEF.md
# E1 Spare-Bit Pattern Monitor

This block sits behind an E1 frame aligner and watches the national spare bits (Sa4 through Sa8) carried in the odd frames. Each spare bit comes in as one accepted transfer on a small stream input. The transfer carries the bit value, which of the five spare bits it is, and its position inside the 4-bit group that the current sub-multiframe forms. A level input says whether basic frame alignment is currently held.

From that stream the block derives three kinds of result. The first is a per-code detection of five fixed Sa6 patterns, either bit by bit or only on nibble boundaries. The second is the V5.2 link-identification condition, found by a sliding majority over the Sa7 bits. The third is a change event for each spare bit whenever its newly completed 4-bit group differs from the previous one. Results are given as status levels, sticky per-code hit bits with write-one-to-clear, and one-cycle event pulses meant for an interrupt collector.

The input never applies back-pressure: `sa_ready` is held high and every cycle with `sa_valid` high is one accepted spare bit. A transfer made while `sync_ok` is low is dropped.

Top module: `sa_spare_mon`

## Requirements
- R1: With `sa6_align`=0 and `sa6_cmp_en`=1, once at least 12 Sa6 bits (`sa_idx`=2) have been taken since the last history clear, the 12 most recent bits are compared after each new Sa6 bit. The first received bit is the most significant. A match pulses `sa6_evt` for one cycle, starting the cycle after the transfer, on bit 0..4 for 0x888, 0xAAA, 0xCCC, 0xEEE and 0xFFF respectively.
- R2: With `sa6_align`=1, the comparison is made only on an Sa6 transfer whose `sa_pos` is 3, so a pattern that ends at any other position gives no event.
- R3: Each `sa6_hit` bit is set in the same cycle as its `sa6_evt` pulse and stays set until it is cleared.
- R4: While `sa6_cmp_en`=0 no Sa6 comparison is made, but Sa6 bits are still shifted into the history.
- R5: A cycle with `clr_we`=1 clears each `sa6_hit` bit whose `clr_mask` bit is 1. A set in the same cycle takes priority over the clear.
- R6: A cycle with `sync_ok`=0 empties the Sa6 history, so 12 fresh Sa6 bits are needed before the next match.
- R7: `v52_link` is 1 when at least 2 of the last 3 Sa7 bits (`sa_idx`=3) taken since the window was cleared were 0. It updates the cycle after each Sa7 transfer, and `v52_evt` pulses for one cycle on every change of `v52_link`.
- R8: A cycle with `sync_ok`=0 empties the Sa7 window, so `v52_link` is 0 the next cycle, and any transfer made while `sync_ok`=0 is ignored.
- R9: For each spare bit X (`sa_idx` 0..4 = Sa4..Sa8), the bits at `sa_pos` 0..3 form a nibble with position 0 as the MSB. This nibble is shown in `sa_nib[4X+3:4X]` the cycle after position 3 arrives. `nib_evt[X]` pulses at the same time if the nibble differs from the previous one. The first nibble after reset gives no event.
- R10: `sa_ready` is always 1, and transfers with `sa_idx` values 5 to 7 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ok | input | 1 | Basic frame alignment held |
| sa6_cmp_en | input | 1 | Enable Sa6 code comparison |
| sa6_align | input | 1 | 0: compare each bit, 1: compare on nibble boundaries only |
| sa_valid | input | 1 | Spare-bit transfer valid |
| sa_ready | output | 1 | Always 1, no back-pressure |
| sa_bit | input | 1 | Spare-bit value |
| sa_idx | input | 3 | Spare-bit index, 0..4 = Sa4..Sa8 |
| sa_pos | input | 2 | Position in the 4-bit group, 3 = last |
| clr_we | input | 1 | Clear write strobe for hit bits |
| clr_mask | input | 5 | Write-one-to-clear mask for `sa6_hit` |
| sa6_hit | output | 5 | Sticky per-code Sa6 hits (888, AAA, CCC, EEE, FFF) |
| sa6_evt | output | 5 | One-cycle per-code Sa6 match pulses |
| v52_link | output | 1 | V5.2 link-identification condition |
| v52_evt | output | 1 | Pulse on each change of `v52_link` |
| nib_evt | output | 5 | Per-spare-bit nibble change pulses |
| sa_nib | output | 20 | Last completed nibble of each spare bit |

## Verification
The hardest situations to reach are those where the Sa6 history is already full from earlier traffic: a pattern that lines up only off a nibble boundary, a match hidden by the disabled comparator, and a set that collides with a clear. The directed tasks reach these on purpose. One feeds a misaligned 13-bit stream in both comparison modes. One fills the history with ones while comparison is off and then turns it on for a single extra nibble. One raises the clear strobe in exactly the cycle of the final matching bit. Loss of sync is forced between partial patterns to show that the stale history cannot complete a match.

// File: rtl/sa_mon_pkg.sv
package sa_mon_pkg;
  localparam int N_SA    = 5;   // Sa4..Sa8
  localparam int N_CODE  = 5;   // Sa6 codes watched
  localparam int SA6_SEL = 2;   // index of Sa6
  localparam int SA7_SEL = 3;   // index of Sa7

  // nibble repeated in code k: 8, A, C, E, then F for the last code
  function automatic logic [3:0] code_nib(input int k, input int ncode);
    if (k == ncode - 1) return 4'hF;
    return 4'(8 + 2 * k);
  endfunction
endpackage

// File: rtl/sa6_code_det.sv
module sa6_code_det #(
  parameter int NIBS  = 3,
  parameter int NCODE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             nib_last,
  input  logic             cmp_en,
  input  logic             align_mode,
  input  logic             clr_we,
  input  logic [NCODE-1:0] clr_mask,
  output logic [NCODE-1:0] hit,
  output logic [NCODE-1:0] evt
);
  import sa_mon_pkg::*;

  localparam int LEN = NIBS * 4;
  localparam int FW  = $clog2(LEN + 1);

  logic [LEN-1:0]   hist_q, hist_nxt;
  logic [FW-1:0]    fill_q;
  logic             full_nxt, cmp_go;
  logic [NCODE-1:0] eq, set_d, evt_q, hit_q;

  assign hist_nxt = {hist_q[LEN-2:0], bit_val};
  assign full_nxt = (fill_q >= FW'(LEN - 1));
  assign cmp_go   = cmp_en && full_nxt && (!align_mode || nib_last);

  for (genvar k = 0; k < NCODE; k++) begin : g_code
    assign eq[k] = (hist_nxt == {NIBS{code_nib(k, NCODE)}});
  end

  assign set_d = (bit_vld && !flush && cmp_go) ? eq : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (flush) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      hist_q <= hist_nxt;
      if (fill_q != FW'(LEN)) fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      hit_q <= '0;
    end else begin
      evt_q <= set_d;
      hit_q <= (hit_q & ~(clr_we ? clr_mask : '0)) | set_d;
    end
  end

  assign evt = evt_q;
  assign hit = hit_q;
endmodule

// File: rtl/sa7_link_win.sv
module sa7_link_win #(
  parameter int WIN = 3,
  parameter int THR = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic bit_vld,
  input  logic bit_val,
  output logic link,
  output logic chg
);
  // one flag per window slot, set when that received bit was zero
  logic [WIN-1:0] zwin_q, zwin_nxt;
  logic           link_cur, link_nxt, chg_q;

  always_comb begin
    zwin_nxt = zwin_q;
    if (flush)        zwin_nxt = '0;
    else if (bit_vld) zwin_nxt = {zwin_q[WIN-2:0], ~bit_val};
  end

  assign link_cur = ($countones(zwin_q)   >= THR);
  assign link_nxt = ($countones(zwin_nxt) >= THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zwin_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      zwin_q <= zwin_nxt;
      chg_q  <= (link_nxt != link_cur);
    end
  end

  assign link = link_cur;
  assign chg  = chg_q;
endmodule

// File: rtl/sa_nib_trk.sv
module sa_nib_trk #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             nib_last,
  output logic [NIB_W-1:0] nib,
  output logic             evt
);
  logic [NIB_W-2:0] part_q;
  logic [NIB_W-1:0] nib_q, nib_new;
  logic             seen_q, evt_q;

  assign nib_new = {part_q, bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
      nib_q  <= '0;
      seen_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (bit_vld) begin
        if (nib_last) begin
          nib_q  <= nib_new;
          seen_q <= 1'b1;
          evt_q  <= seen_q && (nib_new != nib_q);
        end else begin
          part_q <= {part_q[NIB_W-3:0], bit_val};
        end
      end
    end
  end

  assign nib = nib_q;
  assign evt = evt_q;
endmodule

// File: rtl/sa_spare_mon.sv
module sa_spare_mon #(
  parameter int SA6_NIBS = 3,
  parameter int V52_WIN  = 3,
  parameter int V52_THR  = 2,
  parameter int NIB_W    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sync_ok,
  input  logic                                 sa6_cmp_en,
  input  logic                                 sa6_align,
  input  logic                                 sa_valid,
  output logic                                 sa_ready,
  input  logic                                 sa_bit,
  input  logic [2:0]                           sa_idx,
  input  logic [$clog2(NIB_W)-1:0]             sa_pos,
  input  logic                                 clr_we,
  input  logic [sa_mon_pkg::N_CODE-1:0]        clr_mask,
  output logic [sa_mon_pkg::N_CODE-1:0]        sa6_hit,
  output logic [sa_mon_pkg::N_CODE-1:0]        sa6_evt,
  output logic                                 v52_link,
  output logic                                 v52_evt,
  output logic [sa_mon_pkg::N_SA-1:0]          nib_evt,
  output logic [sa_mon_pkg::N_SA*NIB_W-1:0]    sa_nib
);
  import sa_mon_pkg::*;

  localparam int POS_W = $clog2(NIB_W);

  logic             take;
  logic             last_pos;
  logic [N_SA-1:0]  sel;

  assign sa_ready = 1'b1;
  assign take     = sa_valid && sync_ok;
  assign last_pos = (sa_pos == POS_W'(NIB_W - 1));

  for (genvar x = 0; x < N_SA; x++) begin : g_sa
    assign sel[x] = take && (sa_idx == 3'(x));

    sa_nib_trk #(.NIB_W(NIB_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (sel[x]),
      .bit_val  (sa_bit),
      .nib_last (last_pos),
      .nib      (sa_nib[x*NIB_W +: NIB_W]),
      .evt      (nib_evt[x])
    );
  end

  sa6_code_det #(.NIBS(SA6_NIBS), .NCODE(N_CODE)) u_sa6 (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (!sync_ok),
    .bit_vld    (sel[SA6_SEL]),
    .bit_val    (sa_bit),
    .nib_last   (last_pos),
    .cmp_en     (sa6_cmp_en),
    .align_mode (sa6_align),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .hit        (sa6_hit),
    .evt        (sa6_evt)
  );

  sa7_link_win #(.WIN(V52_WIN), .THR(V52_THR)) u_sa7 (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!sync_ok),
    .bit_vld (sel[SA7_SEL]),
    .bit_val (sa_bit),
    .link    (v52_link),
    .chg     (v52_evt)
  );
endmodule

// File: rtl/sa_spare_mon_chk.sv
module sa_spare_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_ok,
  input logic       sa6_cmp_en,
  input logic [4:0] sa6_hit,
  input logic [4:0] sa6_evt,
  input logic       v52_link,
  input logic       v52_evt,
  input logic [4:0] nib_evt
);
  // R1: codes are distinct, at most one code per bit
  assert_one_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sa6_evt));

  // R3: a pulsing code has its sticky bit set
  assert_hit_with_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sa6_evt & ~sa6_hit) == 5'b0);

  // R3: a sticky bit only rises together with its pulse
  assert_hit_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sa6_hit & ~$past(sa6_hit)) & ~sa6_evt) == 5'b0);

  // R4: comparison off gives no pulse
  assert_cmp_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sa6_cmp_en |=> (sa6_evt == 5'b0));

  // R7: change pulse means the level moved
  assert_v52_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v52_evt |-> (v52_link != $past(v52_link)));

  // R8: sync loss drops the link condition
  assert_nosync_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> !v52_link);

  // R8: transfers without sync give no Sa6 or nibble pulses
  assert_nosync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> (sa6_evt == 5'b0 && nib_evt == 5'b0));

  // R9: one transfer completes at most one nibble
  assert_nib_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nib_evt));
endmodule

bind sa_spare_mon sa_spare_mon_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_ok    (sync_ok),
  .sa6_cmp_en (sa6_cmp_en),
  .sa6_hit    (sa6_hit),
  .sa6_evt    (sa6_evt),
  .v52_link   (v52_link),
  .v52_evt    (v52_evt),
  .nib_evt    (nib_evt)
);

// File: tb/sa_spare_mon_tb_top.sv
module sa_spare_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_ok = 1'b0;
  logic        sa6_cmp_en = 1'b1;
  logic        sa6_align = 1'b0;
  logic        sa_valid = 1'b0;
  logic        sa_ready;
  logic        sa_bit = 1'b0;
  logic [2:0]  sa_idx = 3'd0;
  logic [1:0]  sa_pos = 2'd0;
  logic        clr_we = 1'b0;
  logic [4:0]  clr_mask = 5'd0;
  logic [4:0]  sa6_hit, sa6_evt, nib_evt;
  logic        v52_link, v52_evt;
  logic [19:0] sa_nib;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic [4:0] acc6, accn, last6, lastn;
  logic       acc7;

  always #5 clk = ~clk;

  sa_spare_mon dut_i (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .sa6_cmp_en(sa6_cmp_en),
    .sa6_align(sa6_align), .sa_valid(sa_valid), .sa_ready(sa_ready),
    .sa_bit(sa_bit), .sa_idx(sa_idx), .sa_pos(sa_pos), .clr_we(clr_we),
    .clr_mask(clr_mask), .sa6_hit(sa6_hit), .sa6_evt(sa6_evt),
    .v52_link(v52_link), .v52_evt(v52_evt), .nib_evt(nib_evt), .sa_nib(sa_nib)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_acc();
    acc6 = '0; accn = '0; acc7 = 1'b0;
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic send_bit(input int idx, input int pos, input logic b);
    sa_valid = 1'b1; sa_idx = 3'(idx); sa_pos = 2'(pos); sa_bit = b;
    @(posedge clk); @(negedge clk);
    sa_valid = 1'b0;
    last6 = sa6_evt; lastn = nib_evt;
    acc6 |= sa6_evt; accn |= nib_evt; acc7 |= v52_evt;
  endtask

  task automatic send_nib(input int idx, input logic [3:0] n);
    for (int i = 0; i < 4; i++) send_bit(idx, i, n[3-i]);
  endtask

  task automatic drop_sync();
    sync_ok = 1'b0; @(posedge clk); @(negedge clk); sync_ok = 1'b1;
  endtask

  task automatic clear_hits(input logic [4:0] m);
    clr_we = 1'b1; clr_mask = m; @(posedge clk); @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    check("R3 reset hit", 32'(sa6_hit), 0);
    check("R1 reset evt", 32'(sa6_evt), 0);
    check("R7 reset link", 32'(v52_link), 0);
    check("R9 reset nib", 32'(sa_nib), 0);
    check("R10 ready", 32'(sa_ready), 1);
  endtask

  // 0 followed by A,A,A : ends off the nibble boundary (13th bit at pos 0)
  task automatic send_mis_aaa();
    logic [12:0] s = 13'b0_1010_1010_1010;
    for (int i = 0; i < 13; i++) begin
      send_bit(2, i % 4, s[12-i]);
      if (i == 11) check("R1 no early match", 32'(acc6), 0);
    end
  endtask

  task automatic t_serial();
    sa6_align = 1'b0; drop_sync(); clear_acc();
    send_mis_aaa();
    check("R1 serial AAA pulse", 32'(last6), 32'b00010);
    check("R3 sticky AAA", 32'(sa6_hit), 32'b00010);
    send_bit(2, 1, 1'b1);
    check("R1 pulse one cycle", 32'(last6), 0);
    check("R3 sticky held", 32'(sa6_hit), 32'b00010);
  endtask

  task automatic t_aligned();
    clear_hits(5'b11111);
    check("R5 clear all", 32'(sa6_hit), 0);
    sa6_align = 1'b1; drop_sync(); clear_acc();
    send_mis_aaa();
    check("R2 misaligned ignored", 32'(acc6), 0);
    send_nib(2, 4'hC); send_nib(2, 4'hC); send_nib(2, 4'hC);
    check("R2 aligned CCC pulse", 32'(last6), 32'b00100);
    check("R2 only CCC seen", 32'(acc6), 32'b00100);
  endtask

  task automatic t_enable();
    sa6_cmp_en = 1'b0; drop_sync(); clear_acc();
    for (int j = 0; j < 3; j++) send_nib(2, 4'hF);
    check("R4 disabled no pulse", 32'(acc6), 0);
    check("R4 disabled no hit", 32'(sa6_hit), 32'b00100);
    sa6_cmp_en = 1'b1;
    send_nib(2, 4'hF);
    check("R4 history kept shifting", 32'(last6), 32'b10000);
    check("R4 FFF hit", 32'(sa6_hit), 32'b10100);
  endtask

  task automatic t_clear();
    clear_hits(5'b00100);
    check("R5 masked clear", 32'(sa6_hit), 32'b10000);
    for (int i = 0; i < 3; i++) send_bit(2, i, 1'b1);
    clr_we = 1'b1; clr_mask = 5'b11111;
    send_bit(2, 3, 1'b1);
    clr_we = 1'b0; clr_mask = '0;
    check("R5 set beats clear", 32'(sa6_hit), 32'b10000);
    clear_hits(5'b11111);
    check("R5 clear after", 32'(sa6_hit), 0);
  endtask

  task automatic t_sync_sa6();
    sa6_align = 1'b0; drop_sync(); clear_acc();
    send_nib(2, 4'h8); send_nib(2, 4'h8);
    drop_sync();
    send_nib(2, 4'h8);
    check("R6 stale history no match", 32'(acc6), 0);
    send_nib(2, 4'h8); send_nib(2, 4'h8);
    check("R6 fresh 888 match", 32'(last6), 32'b00001);
  endtask

  task automatic t_v52();
    drop_sync(); clear_acc();
    send_bit(3, 0, 1'b1);
    check("R7 one bit link", 32'(v52_link), 0);
    send_bit(3, 1, 1'b0);
    check("R7 one zero link", 32'(v52_link), 0);
    send_bit(3, 2, 1'b0);
    check("R7 two zeros link", 32'(v52_link), 1);
    check("R7 rise pulse", 32'(v52_evt), 1);
    send_bit(3, 3, 1'b1);
    check("R7 001 window link", 32'(v52_link), 1);
    check("R7 no pulse when steady", 32'(v52_evt), 0);
    send_bit(3, 0, 1'b1);
    check("R7 one zero left", 32'(v52_link), 0);
    check("R7 fall pulse", 32'(v52_evt), 1);
    send_bit(3, 1, 1'b0); send_bit(3, 2, 1'b0);
    check("R7 relink", 32'(v52_link), 1);
    sync_ok = 1'b0;
    send_bit(3, 3, 1'b0);
    check("R8 link drops on sync loss", 32'(v52_link), 0);
    send_bit(3, 0, 1'b0);
    check("R8 bits ignored without sync", 32'(v52_link), 0);
    sync_ok = 1'b1;
    send_bit(3, 1, 1'b0);
    check("R8 window restarted", 32'(v52_link), 0);
    send_bit(3, 2, 1'b0);
    check("R8 link after two fresh zeros", 32'(v52_link), 1);
  endtask

  task automatic t_nibble();
    logic [19:0] snap;
    clear_acc();
    send_nib(0, 4'h5);
    check("R9 first nibble no event", 32'(accn), 0);
    check("R9 Sa4 nibble shown", 32'(sa_nib[3:0]), 32'h5);
    send_nib(0, 4'h5);
    check("R9 same nibble no event", 32'(accn), 0);
    send_nib(0, 4'h6);
    check("R9 Sa4 change event", 32'(lastn), 32'b00001);
    check("R9 Sa4 new value", 32'(sa_nib[3:0]), 32'h6);
    clear_acc();
    send_nib(4, 4'h3); send_nib(4, 4'h3);
    check("R9 Sa8 steady no event", 32'(accn), 0);
    send_nib(4, 4'hC);
    check("R9 Sa8 change event", 32'(lastn), 32'b10000);
    check("R9 Sa8 value", 32'(sa_nib[19:16]), 32'hC);
    snap = sa_nib; clear_acc();
    send_nib(5, 4'hF); send_nib(7, 4'h0);
    check("R10 bad index no event", 32'(accn | acc6), 0);
    check("R10 bad index no change", 32'(sa_nib), 32'(snap));
    check("R10 ready held", 32'(sa_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; sync_ok = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_aligned();
    t_enable();
    t_clear();
    t_sync_sa6();
    t_v52();
    t_nibble();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule